// File: doc/BRIEF.md
# Single-Lane Vector Load/Store Unit

This unit carries out single-element structure accesses between a 32-entry file of 128-bit vector registers and a byte-addressed memory. One command names a starting vector register, an element width (8, 16, 32 or 64 bits), a lane number, a structure count from one to four, a width flag for broadcasts, and whether the base address is updated afterwards. A sequencer then walks the structure one element at a time. The element's memory offset grows by its byte count. The register number steps by one and wraps from 31 to 0.

Three operations are supported. A lane store copies one lane of each register to memory and leaves the registers as they were. A lane load fetches one element per register and rewrites that register with only the chosen lane changed. A replicate load fetches one element per register and fills the register with copies of it: the whole 128 bits when the width flag is set, and only the lower 64 bits, with the upper half cleared, when it is clear. When writeback is requested, the unit reports a new base: either the old base plus an offset supplied by the caller, or the old base plus the total bytes moved.

The caller supplies the base value and the offset value with the command. The vector file and the memory sit outside the block. Register reads are combinational. Memory read data arrives one cycle after the request.

Top module: `slvu_top`

## Requirements
- R1: While reset is high and in the cycle after it, `done`, `busy`, `mem_req`, `vwr_en` and `wb_en` are low.
- R2: Store (`op`=0): for element k (0..`nstruct`), exactly one write of 2^`esize` bytes goes to address `base`+k·2^`esize`. Its bytes, lowest address first, are bytes `lane`·2^`esize` upward of register (`rt`+k) mod 32. No vector register is written.
- R3: Lane load (`op`=1): register (`rt`+k) mod 32 keeps every byte except bytes `lane`·2^`esize` through `lane`·2^`esize`+2^`esize`−1. Those bytes take, lowest first, the bytes at `base`+k·2^`esize` upward.
- R4: Replicate (`op`=2): register (`rt`+k) mod 32 has byte j equal to memory byte `base`+k·2^`esize`+(j mod 2^`esize`). When `q`=0, bytes 8 to 15 are instead zero. `lane` is not used.
- R5: The register number wraps from 31 to 0 within one command.
- R6: With `wback`=1 and no fault, `wb_en` pulses together with `done`. `wb_data` is `base`+`xm` when `rm`≠31, and `base`+(`nstruct`+1)·2^`esize` when `rm`=31. With `wback`=0, `wb_en` stays low.
- R7: For `op` 0 or 1, a lane with `lane` ≥ 16/2^`esize` raises `fault` with `done`. No memory access, register write or writeback takes place.
- R8: When `rn`=31 and `base[3:0]`≠0, the command faults with the same suppression as R7.
- R9: A `start` that arrives while `busy` is high is ignored.
- R10: `done` is a one-cycle pulse, and `fault` is high only while `done` is high.
- R11: `op`=3 is reserved and faults with the same suppression as R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept a command when idle |
| op | input | 2 | 0 store, 1 lane load, 2 replicate, 3 reserved |
| esize | input | 2 | log2 of the element byte count |
| lane | input | 4 | Lane number |
| nstruct | input | 2 | Number of elements minus one |
| q | input | 1 | Full-width broadcast when set |
| rt | input | 5 | First vector register |
| rn | input | 5 | Base register number (31 = stack pointer) |
| rm | input | 5 | Offset register number (31 = use bytes moved) |
| wback | input | 1 | Report an updated base |
| base | input | 64 | Base address value |
| xm | input | 64 | Offset register value |
| busy | output | 1 | Command in progress |
| done | output | 1 | Completion pulse |
| fault | output | 1 | Command was refused |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_size | output | 2 | log2 of the access byte count |
| mem_addr | output | 64 | Byte address |
| mem_wdata | output | 64 | Write data, little-endian, low bytes used |
| mem_rdata | input | 64 | Read data, valid the cycle after a read request |
| vrd_addr | output | 5 | Vector register read index |
| vrd_data | input | 128 | Vector register read data |
| vwr_en | output | 1 | Vector register write enable |
| vwr_addr | output | 5 | Vector register write index |
| vwr_data | output | 128 | Vector register write data |
| wb_en | output | 1 | Base update strobe |
| wb_data | output | 64 | Updated base value |

## Verification
The bench goes after lane placement at every element width and at the highest legal lane. A shifter that scaled the lane by bits instead of bytes would corrupt the wrong bytes there. Register runs that start at 30 or 31 check the wrap: a unit without it would write past the file or stall. Replicate loads with `q` clear test the upper-half clear, because a missing clear leaves copies in bytes 8 to 15. Writeback is tried with `rm` at 31 and at other values, so that adding the wrong offset shows up. The bench also sends illegal lanes, misaligned stack bases, the reserved op and a second `start` while busy. A design that let any of these through would change memory, registers or the base.

// File: rtl/slvu_pkg.sv
package slvu_pkg;
  typedef enum logic [1:0] {
    OP_STORE = 2'd0,
    OP_LOAD  = 2'd1,
    OP_REPL  = 2'd2,
    OP_RSVD  = 2'd3
  } slvu_op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ISSUE = 3'd1,
    ST_MEM   = 3'd2,
    ST_MERGE = 3'd3,
    ST_FIN   = 3'd4
  } slvu_state_e;

  // low-byte mask for an element of 2**sz bytes within an ELEN-bit word
  function automatic logic [63:0] size_mask(input logic [1:0] sz);
    logic [63:0] m;
    m = '0;
    for (int b = 0; b < 8; b++) begin
      if (b < (1 << sz)) m[b*8 +: 8] = 8'hFF;
    end
    return m;
  endfunction
endpackage

// File: rtl/slvu_check.sv
module slvu_check #(
  parameter int VLEN  = 128,
  parameter int LW    = $clog2(VLEN/8),
  parameter int RIDXW = 5
) (
  input  logic [1:0]       op,
  input  logic [1:0]       esize,
  input  logic [LW-1:0]    lane,
  input  logic [RIDXW-1:0] rn,
  input  logic [3:0]       base_lo,
  output logic             bad
);
  import slvu_pkg::*;
  localparam int VBYTES = VLEN / 8;
  localparam logic [RIDXW-1:0] SP_IDX = '1;

  logic [LW:0] lane_lim;
  logic        lane_bad;
  logic        sp_bad;

  always_comb begin
    lane_lim = (LW+1)'(VBYTES) >> esize;
    lane_bad = (op != OP_REPL) && ({1'b0, lane} >= lane_lim);
    sp_bad   = (rn == SP_IDX) && (base_lo != 4'd0);
    bad      = lane_bad || sp_bad || (op == OP_RSVD);
  end
endmodule

// File: rtl/slvu_lane_pick.sv
module slvu_lane_pick #(
  parameter int VLEN = 128,
  parameter int ELEN = 64,
  parameter int LW   = $clog2(VLEN/8)
) (
  input  logic [VLEN-1:0] vec,
  input  logic [1:0]      esize,
  input  logic [LW-1:0]   lane,
  output logic [ELEN-1:0] elem
);
  import slvu_pkg::*;
  localparam int BW = $clog2(VLEN);

  logic [BW-1:0]   bit_off;
  logic [VLEN-1:0] shifted;

  always_comb begin
    bit_off = ({{(BW-LW){1'b0}}, lane} << esize) << 3;
    shifted = vec >> bit_off;
    elem    = shifted[ELEN-1:0] & size_mask(esize);
  end
endmodule

// File: rtl/slvu_lane_fill.sv
module slvu_lane_fill #(
  parameter int VLEN = 128,
  parameter int ELEN = 64,
  parameter int LW   = $clog2(VLEN/8)
) (
  input  logic [VLEN-1:0] old_vec,
  input  logic [ELEN-1:0] mem_elem,
  input  logic [1:0]      esize,
  input  logic [LW-1:0]   lane,
  input  logic            repl,
  input  logic            full,
  output logic [VLEN-1:0] new_vec
);
  import slvu_pkg::*;
  localparam int BW  = $clog2(VLEN);
  localparam int NSZ = $clog2(ELEN/8) + 1;

  logic [BW-1:0]   bit_off;
  logic [VLEN-1:0] ins_mask;
  logic [VLEN-1:0] ins_data;
  logic [VLEN-1:0] rep_pick;

  for (genvar gs = 0; gs < NSZ; gs++) begin : g_rep
    localparam int EB = 8 << gs;
    logic [VLEN-1:0] r;
    for (genvar gj = 0; gj < VLEN/EB; gj++) begin : g_copy
      assign r[gj*EB +: EB] = mem_elem[EB-1:0];
    end
  end

  always_comb begin
    bit_off  = ({{(BW-LW){1'b0}}, lane} << esize) << 3;
    ins_mask = {{(VLEN-ELEN){1'b0}}, size_mask(esize)} << bit_off;
    ins_data = {{(VLEN-ELEN){1'b0}}, mem_elem & size_mask(esize)} << bit_off;
    case (esize)
      2'd0:    rep_pick = g_rep[0].r;
      2'd1:    rep_pick = g_rep[1].r;
      2'd2:    rep_pick = g_rep[2].r;
      default: rep_pick = g_rep[3].r;
    endcase
    if (!full) rep_pick[VLEN-1:VLEN/2] = '0;
    new_vec = repl ? rep_pick : ((old_vec & ~ins_mask) | ins_data);
  end
endmodule

// File: rtl/slvu_top.sv
module slvu_top #(
  parameter int VLEN  = 128,
  parameter int ELEN  = 64,
  parameter int AW    = 64,
  parameter int RIDXW = 5,
  parameter int LW    = $clog2(VLEN/8),
  parameter int CNTW  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       op,
  input  logic [1:0]       esize,
  input  logic [LW-1:0]    lane,
  input  logic [CNTW-1:0]  nstruct,
  input  logic             q,
  input  logic [RIDXW-1:0] rt,
  input  logic [RIDXW-1:0] rn,
  input  logic [RIDXW-1:0] rm,
  input  logic             wback,
  input  logic [AW-1:0]    base,
  input  logic [AW-1:0]    xm,
  output logic             busy,
  output logic             done,
  output logic             fault,
  output logic             mem_req,
  output logic             mem_we,
  output logic [1:0]       mem_size,
  output logic [AW-1:0]    mem_addr,
  output logic [ELEN-1:0]  mem_wdata,
  input  logic [ELEN-1:0]  mem_rdata,
  output logic [RIDXW-1:0] vrd_addr,
  input  logic [VLEN-1:0]  vrd_data,
  output logic             vwr_en,
  output logic [RIDXW-1:0] vwr_addr,
  output logic [VLEN-1:0]  vwr_data,
  output logic             wb_en,
  output logic [AW-1:0]    wb_data
);
  import slvu_pkg::*;
  localparam logic [RIDXW-1:0] ZR_IDX = '1;

  slvu_state_e     state_q;
  logic [1:0]      op_q;
  logic [1:0]      es_q;
  logic [LW-1:0]   lane_q;
  logic [CNTW-1:0] left_q;
  logic            q_q;
  logic [RIDXW-1:0] t_q;
  logic [RIDXW-1:0] rm_q;
  logic            wback_q;
  logic [AW-1:0]   base_q;
  logic [AW-1:0]   xm_q;
  logic [AW-1:0]   offs_q;
  logic            fault_q;

  logic            cmd_bad;
  logic [ELEN-1:0] pick_elem;
  logic [VLEN-1:0] fill_vec;
  logic [AW-1:0]   ebytes;

  slvu_check #(.VLEN(VLEN), .LW(LW), .RIDXW(RIDXW)) u_check (
    .op      (op),
    .esize   (esize),
    .lane    (lane),
    .rn      (rn),
    .base_lo (base[3:0]),
    .bad     (cmd_bad)
  );

  slvu_lane_pick #(.VLEN(VLEN), .ELEN(ELEN), .LW(LW)) u_pick (
    .vec   (vrd_data),
    .esize (es_q),
    .lane  (lane_q),
    .elem  (pick_elem)
  );

  slvu_lane_fill #(.VLEN(VLEN), .ELEN(ELEN), .LW(LW)) u_fill (
    .old_vec  (vrd_data),
    .mem_elem (mem_rdata),
    .esize    (es_q),
    .lane     (lane_q),
    .repl     (op_q == OP_REPL),
    .full     (q_q),
    .new_vec  (fill_vec)
  );

  assign ebytes   = AW'(1) << es_q;
  assign vrd_addr = t_q;
  assign busy     = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      op_q      <= '0;
      es_q      <= '0;
      lane_q    <= '0;
      left_q    <= '0;
      q_q       <= 1'b0;
      t_q       <= '0;
      rm_q      <= '0;
      wback_q   <= 1'b0;
      base_q    <= '0;
      xm_q      <= '0;
      offs_q    <= '0;
      fault_q   <= 1'b0;
      done      <= 1'b0;
      fault     <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_size  <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      vwr_en    <= 1'b0;
      vwr_addr  <= '0;
      vwr_data  <= '0;
      wb_en     <= 1'b0;
      wb_data   <= '0;
    end else begin
      done    <= 1'b0;
      fault   <= 1'b0;
      mem_req <= 1'b0;
      vwr_en  <= 1'b0;
      wb_en   <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            op_q    <= op;
            es_q    <= esize;
            lane_q  <= lane;
            left_q  <= nstruct;
            q_q     <= q;
            t_q     <= rt;
            rm_q    <= rm;
            wback_q <= wback;
            base_q  <= base;
            xm_q    <= xm;
            offs_q  <= '0;
            fault_q <= cmd_bad;
            state_q <= cmd_bad ? ST_FIN : ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          mem_req   <= 1'b1;
          mem_we    <= (op_q == OP_STORE);
          mem_size  <= es_q;
          mem_addr  <= base_q + offs_q;
          mem_wdata <= pick_elem;
          state_q   <= ST_MEM;
        end
        ST_MEM: begin
          if (op_q == OP_STORE) begin
            t_q    <= t_q + 1'b1;
            offs_q <= offs_q + ebytes;
            if (left_q == '0) state_q <= ST_FIN;
            else begin
              left_q  <= left_q - 1'b1;
              state_q <= ST_ISSUE;
            end
          end else begin
            state_q <= ST_MERGE;
          end
        end
        ST_MERGE: begin
          vwr_en   <= 1'b1;
          vwr_addr <= t_q;
          vwr_data <= fill_vec;
          t_q      <= t_q + 1'b1;
          offs_q   <= offs_q + ebytes;
          if (left_q == '0) state_q <= ST_FIN;
          else begin
            left_q  <= left_q - 1'b1;
            state_q <= ST_ISSUE;
          end
        end
        ST_FIN: begin
          done  <= 1'b1;
          fault <= fault_q;
          if (!fault_q && wback_q) begin
            wb_en   <= 1'b1;
            wb_data <= base_q + ((rm_q != ZR_IDX) ? xm_q : offs_q);
          end
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/slvu_chk.sv
module slvu_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic done,
  input logic fault,
  input logic mem_req,
  input logic mem_we,
  input logic vwr_en,
  input logic wb_en
);
  p_quiet_after_reset_r1: assert property (@(posedge clk)
    rst |=> (!done && !busy && !mem_req && !vwr_en && !wb_en));

  p_store_keeps_regs_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> !vwr_en);

  p_wb_with_done_r6: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> done);

  p_fault_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (done && fault) |-> (!wb_en && !vwr_en && !mem_req));

  p_idle_start_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_fault_only_done_r10: assert property (@(posedge clk) disable iff (rst)
    fault |-> done);

  p_mem_single_r2: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);
endmodule

bind slvu_top slvu_chk u_slvu_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .fault   (fault),
  .mem_req (mem_req),
  .mem_we  (mem_we),
  .vwr_en  (vwr_en),
  .wb_en   (wb_en)
);

// File: tb/slvu_top_tb.sv
`timescale 1ns/1ps
module slvu_top_tb_top;
  logic         clk = 1'b0;
  logic         rst;
  logic         start;
  logic [1:0]   op;
  logic [1:0]   esize;
  logic [3:0]   lane;
  logic [1:0]   nstruct;
  logic         q;
  logic [4:0]   rt, rn, rm;
  logic         wback;
  logic [63:0]  base, xm;
  logic         busy, done, fault;
  logic         mem_req, mem_we;
  logic [1:0]   mem_size;
  logic [63:0]  mem_addr, mem_wdata, mem_rdata;
  logic [4:0]   vrd_addr;
  logic [127:0] vrd_data;
  logic         vwr_en;
  logic [4:0]   vwr_addr;
  logic [127:0] vwr_data;
  logic         wb_en;
  logic [63:0]  wb_data;

  logic [127:0] vregs [32];
  logic [7:0]   mem [256];
  logic [127:0] exp_v [32];
  logic [7:0]   exp_mem [256];
  logic         exp_fault, exp_wb_en;
  logic [63:0]  exp_wb;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  slvu_top dut_i (
    .clk(clk), .rst(rst), .start(start), .op(op), .esize(esize), .lane(lane),
    .nstruct(nstruct), .q(q), .rt(rt), .rn(rn), .rm(rm), .wback(wback),
    .base(base), .xm(xm), .busy(busy), .done(done), .fault(fault),
    .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .vrd_addr(vrd_addr), .vrd_data(vrd_data), .vwr_en(vwr_en),
    .vwr_addr(vwr_addr), .vwr_data(vwr_data), .wb_en(wb_en), .wb_data(wb_data)
  );

  assign vrd_data = vregs[vrd_addr];

  always @(posedge clk) begin
    if (vwr_en) vregs[vwr_addr] <= vwr_data;
    if (mem_req) begin
      for (int b = 0; b < 8; b++) begin
        if (mem_we) begin
          if (b < (1 << mem_size)) mem[8'(mem_addr + 64'(b))] <= mem_wdata[b*8 +: 8];
        end else begin
          mem_rdata[b*8 +: 8] <= mem[8'(mem_addr + 64'(b))];
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // expected result, computed from the requirements
  task automatic model(input logic [1:0] o, input logic [1:0] es, input logic [3:0] ln,
                       input logic [1:0] ns, input logic qq, input logic [4:0] t0,
                       input logic [4:0] bn, input logic [4:0] mi, input logic wbk,
                       input logic [63:0] b0, input logic [63:0] xv);
    int eb;
    eb = 1 << es;
    for (int r = 0; r < 32; r++) exp_v[r] = vregs[r];
    for (int a = 0; a < 256; a++) exp_mem[a] = mem[a];
    exp_fault = (o == 2'd3) || (o != 2'd2 && int'(ln) >= (16 >> es)) ||
                (bn == 5'd31 && b0[3:0] != 4'd0);
    exp_wb_en = !exp_fault && wbk;
    exp_wb    = b0 + ((mi != 5'd31) ? xv : 64'((int'(ns) + 1) * eb));
    if (!exp_fault) begin
      for (int k = 0; k <= int'(ns); k++) begin
        int r;
        logic [63:0] a;
        r = (int'(t0) + k) % 32;
        a = b0 + 64'(k * eb);
        for (int j = 0; j < 16; j++) begin
          if (o == 2'd0) begin
            if (j < eb) exp_mem[8'(a + 64'(j))] = exp_v[r][(int'(ln)*eb + j)*8 +: 8];
          end else if (o == 2'd1) begin
            if (j < eb) exp_v[r][(int'(ln)*eb + j)*8 +: 8] = exp_mem[8'(a + 64'(j))];
          end else begin
            exp_v[r][j*8 +: 8] = (!qq && j >= 8) ? 8'h00 : exp_mem[8'(a + 64'(j % eb))];
          end
        end
      end
    end
  endtask

  task automatic run_cmd(input string tag, input logic [1:0] o, input logic [1:0] es,
                         input logic [3:0] ln, input logic [1:0] ns, input logic qq,
                         input logic [4:0] t0, input logic [4:0] bn, input logic [4:0] mi,
                         input logic wbk, input logic [63:0] b0, input logic [63:0] xv,
                         input bit poke);
    int wd;
    bit regs_ok, mem_ok;
    logic got_fault, got_wb_en;
    logic [63:0] got_wb;
    model(o, es, ln, ns, qq, t0, bn, mi, wbk, b0, xv);
    @(negedge clk);
    op = o; esize = es; lane = ln; nstruct = ns; q = qq; rt = t0; rn = bn;
    rm = mi; wback = wbk; base = b0; xm = xv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R9: second command while busy must be ignored
      op = 2'd0; rt = t0 + 5'd7; base = b0 + 64'd40; lane = 4'd0; esize = 2'd0;
      wback = 1'b1; rm = 5'd3; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wd = 0;
    while (!done && wd < 100) begin
      @(negedge clk);
      wd++;
    end
    check(wd < 100, tag, "completion timeout", 128'(wd), 128'd0);
    got_fault = fault; got_wb_en = wb_en; got_wb = wb_data;
    repeat (3) @(negedge clk);
    check(!done && !fault, "R10", "done/fault pulse width", {126'd0, done, fault}, 128'd0);
    check(got_fault == exp_fault, tag, "fault", 128'(got_fault), 128'(exp_fault));
    check(got_wb_en == exp_wb_en && (!exp_wb_en || got_wb == exp_wb),
          exp_fault ? tag : "R6", "writeback", {63'd0, got_wb_en, got_wb},
          {63'd0, exp_wb_en, exp_wb});
    regs_ok = 1'b1;
    for (int r = 0; r < 32; r++) begin
      if (vregs[r] !== exp_v[r]) begin
        if (regs_ok) check(1'b0, tag, $sformatf("vreg %0d", r), vregs[r], exp_v[r]);
        regs_ok = 1'b0;
      end
    end
    if (regs_ok) check(1'b1, tag, "vregs", 128'd0, 128'd0);
    mem_ok = 1'b1;
    for (int a = 0; a < 256; a++) begin
      if (mem[a] !== exp_mem[a]) begin
        if (mem_ok) check(1'b0, tag, $sformatf("mem byte %0d", a), 128'(mem[a]), 128'(exp_mem[a]));
        mem_ok = 1'b0;
      end
    end
    if (mem_ok) check(1'b1, tag, "memory", 128'd0, 128'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4242));
    for (int r = 0; r < 32; r++) vregs[r] = {$urandom, $urandom, $urandom, $urandom};
    for (int a = 0; a < 256; a++) mem[a] = 8'($urandom);
    rst = 1'b1; start = 1'b0; op = '0; esize = '0; lane = '0; nstruct = '0;
    q = 1'b0; rt = '0; rn = '0; rm = '0; wback = 1'b0; base = '0; xm = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!done && !busy && !mem_req && !vwr_en && !wb_en, "R1", "reset outputs",
          {123'd0, done, busy, mem_req, vwr_en, wb_en}, 128'd0);
    rst = 1'b0;
    @(negedge clk);
    check(!done && !busy && !mem_req && !vwr_en && !wb_en, "R1", "after reset",
          {123'd0, done, busy, mem_req, vwr_en, wb_en}, 128'd0);

    // directed corners
    run_cmd("R2", 2'd0, 2'd0, 4'd15, 2'd3, 1'b1, 5'd4,  5'd2,  5'd31, 1'b1, 64'd16,  64'd0, 0);
    run_cmd("R2", 2'd0, 2'd3, 4'd1,  2'd1, 1'b0, 5'd9,  5'd2,  5'd5,  1'b1, 64'd64,  64'd100, 0);
    run_cmd("R3", 2'd1, 2'd1, 4'd7,  2'd2, 1'b0, 5'd12, 5'd1,  5'd31, 1'b1, 64'd130, 64'd0, 0);
    run_cmd("R3", 2'd1, 2'd2, 4'd3,  2'd0, 1'b0, 5'd0,  5'd1,  5'd31, 1'b0, 64'd200, 64'd0, 0);
    run_cmd("R4", 2'd2, 2'd0, 4'd9,  2'd1, 1'b0, 5'd20, 5'd3,  5'd31, 1'b1, 64'd7,   64'd0, 0);
    run_cmd("R4", 2'd2, 2'd2, 4'd0,  2'd1, 1'b1, 5'd22, 5'd3,  5'd31, 1'b0, 64'd40,  64'd0, 0);
    run_cmd("R5", 2'd1, 2'd0, 4'd2,  2'd3, 1'b0, 5'd30, 5'd4,  5'd31, 1'b1, 64'd90,  64'd0, 0);
    run_cmd("R5", 2'd0, 2'd1, 4'd5,  2'd2, 1'b0, 5'd31, 5'd4,  5'd31, 1'b1, 64'd150, 64'd0, 0);
    run_cmd("R6", 2'd0, 2'd2, 4'd2,  2'd0, 1'b0, 5'd1,  5'd31, 5'd8,  1'b1, 64'h1000_0000_0000_0030, 64'hFFFF_FFFF_FFFF_FFF0, 0);
    run_cmd("R7", 2'd0, 2'd3, 4'd2,  2'd0, 1'b0, 5'd1,  5'd6,  5'd31, 1'b1, 64'd32,  64'd0, 0);
    run_cmd("R7", 2'd1, 2'd1, 4'd8,  2'd1, 1'b0, 5'd1,  5'd6,  5'd31, 1'b1, 64'd32,  64'd0, 0);
    run_cmd("R8", 2'd1, 2'd0, 4'd0,  2'd0, 1'b0, 5'd1,  5'd31, 5'd31, 1'b1, 64'd36,  64'd0, 0);
    run_cmd("R11", 2'd3, 2'd0, 4'd0, 2'd0, 1'b0, 5'd1,  5'd6,  5'd31, 1'b1, 64'd32,  64'd0, 0);
    run_cmd("R9", 2'd1, 2'd1, 4'd4,  2'd3, 1'b0, 5'd10, 5'd6,  5'd31, 1'b1, 64'd100, 64'd0, 1);

    // constrained random
    for (int n = 0; n < 80; n++) begin
      logic [1:0] o, es, ns;
      logic [3:0] ln;
      logic [4:0] bn, mi;
      logic [63:0] b0;
      string tag;
      o  = 2'($urandom % 3);
      es = 2'($urandom % 4);
      ln = ($urandom % 10 == 0) ? 4'($urandom) : 4'($urandom % (16 >> es));
      ns = 2'($urandom);
      bn = ($urandom % 5 == 0) ? 5'd31 : 5'($urandom % 31);
      mi = ($urandom % 2 == 0) ? 5'd31 : 5'($urandom % 31);
      b0 = {$urandom, $urandom};
      if (bn == 5'd31 && $urandom % 4 != 0) b0[3:0] = 4'd0;
      tag = (o == 2'd0) ? "R2" : (o == 2'd1) ? "R3" : "R4";
      run_cmd(tag, o, es, ln, ns, 1'($urandom), 5'($urandom), bn, mi, 1'($urandom),
              b0, {$urandom, $urandom}, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule